// File: doc/BRIEF.md
# Harvard-Style Accumulator Sequencer

This block is a small machine that runs a program one instruction per clock, with no stalls between instructions. It keeps the program and the operands in two separate internal arrays, a code store and a data store. A single program counter addresses both arrays at once. On each step the block reads the opcode byte at the counter from the code store and the operand byte at the same address from the data store. It then updates an 8-bit accumulator or writes the accumulator back into the data store. The step either advances the counter or halts the machine.

Arithmetic uses a single 8-bit adder. The adder's second input passes through a controlled inverter, and the low bit of the opcode drives both that inverter and the adder's carry-in. The same adder therefore performs both Add and Subtract. A 2-to-1 selector in front of the accumulator picks either the raw data-store byte (for Load) or the adder result.

Before a run, a loader port fills either array while the synchronous clear is held. A read-only peek port shows the contents of either array without disturbing execution.

Top module: `accum_stepper`

## Requirements
- R1: While `clr` is high at a rising clock edge, the next state is `pc` = 0000h, `acc` = 00h and `halted` = 0. The arrays keep their contents.
- R2: Opcode 10h (Load) copies the data-store byte at the current address into `acc`.
- R3: Opcode 20h (Add) sets `acc` to `acc` plus the data-store byte, modulo 256. The carry-out is dropped.
- R4: Opcode 21h (Subtract) sets `acc` to `acc` minus the data-store byte, modulo 256. Bit 0 of the opcode inverts the operand and forces the carry-in high. Starting from 56h, Add 2Ah gives 80h and then Subtract 38h gives 48h.
- R5: Opcode 11h (Store) writes `acc` into the data store at the current address and leaves `acc` unchanged. No other opcode writes the data store.
- R6: Both arrays are read at the low `MEM_AW` bits of one counter. Every executed instruction other than FFh increments `pc` by one, one instruction per clock.
- R7: Opcode FFh (Halt) raises `halted` on the next edge and leaves `pc` unchanged. While `halted` is high, `pc`, `acc` and the data store hold their values until `clr`.
- R8: Any other opcode changes neither `acc` nor the data store, and `pc` still advances.
- R9: When `ld_en` is high, a rising edge writes `ld_data` at `ld_addr`, into the code store if `ld_sel` = 0 and into the data store if `ld_sel` = 1. `peek_data` shows the byte at `peek_addr` combinationally, from the code store if `peek_sel` = 0 and from the data store if `peek_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of counter, accumulator and halt flag |
| ld_en | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 code store, 1 data store |
| ld_addr | input | MEM_AW | Loader address |
| ld_data | input | 8 | Loader byte |
| peek_sel | input | 1 | Peek source: 0 code store, 1 data store |
| peek_addr | input | MEM_AW | Peek address |
| peek_data | output | 8 | Byte at the peek address |
| acc | output | 8 | Accumulator |
| pc | output | PC_W | Program counter |
| halted | output | 1 | High once a Halt has executed, until clear |

## Verification
A fault in the accumulator path appears on `acc` on the edge right after the faulty instruction. A fault in the counter appears on `pc` in that same cycle, and from then on every later step fetches from the wrong address. A wrong or missing Store, or a write on a non-Store opcode, is not visible on `acc`. It shows only when the peek port reads the affected data-store byte after the run, so the bench sweeps every data address after each program. A halt flag that fails to set or to hold shows on `pc` moving past the Halt address within one clock.

// File: rtl/accum_stepper_pkg.sv
package accum_stepper_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [WORD_W-1:0] {
        OP_LOAD  = 8'h10,
        OP_STORE = 8'h11,
        OP_ADD   = 8'h20,
        OP_SUB   = 8'h21,
        OP_HALT  = 8'hFF
    } opcode_e;

    // decoded control lines for one step
    typedef struct packed {
        logic take_mem;  // selector picks the data-store byte
        logic use_alu;   // selector picks the adder result
        logic invert;    // operand inverted, carry-in forced high
        logic wr_mem;    // data-store write of the accumulator
        logic stop;      // halt request
    } ctrl_t;

endpackage

// File: rtl/accum_stepper_decode.sv
module accum_stepper_decode
    import accum_stepper_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    output ctrl_t             ctrl
);

    always_comb begin
        ctrl = '0;
        case (op)
            OP_LOAD:        ctrl.take_mem = 1'b1;
            OP_STORE:       ctrl.wr_mem   = 1'b1;
            OP_ADD, OP_SUB: begin
                ctrl.use_alu = 1'b1;
                ctrl.invert  = op[0];
            end
            OP_HALT:        ctrl.stop     = 1'b1;
            default:        ctrl          = '0;
        endcase
    end

endmodule

// File: rtl/accum_stepper_alu.sv
module accum_stepper_alu
    import accum_stepper_pkg::*;
(
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] operand,
    input  ctrl_t             ctrl,
    output logic [WORD_W-1:0] result
);

    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] sum;

    always_comb begin
        addend = operand ^ {WORD_W{ctrl.invert}};
        sum    = acc_in + addend + WORD_W'(ctrl.invert);
        result = ctrl.take_mem ? operand : sum;
    end

endmodule

// File: rtl/accum_stepper_mem.sv
module accum_stepper_mem #(
    parameter int W  = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd,
    input  logic [AW-1:0] rb,
    output logic [W-1:0]  rdb
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rd  = cells[ra];
    assign rdb = cells[rb];

endmodule

// File: rtl/accum_stepper.sv
module accum_stepper
    import accum_stepper_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              peek_sel,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data,
    output logic [WORD_W-1:0] acc,
    output logic [PC_W-1:0]   pc,
    output logic              halted
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [WORD_W-1:0] acc;
        logic              halted;
    } state_t;

    state_t st_d, st_q;

    logic [MEM_AW-1:0] mem_addr;
    logic [WORD_W-1:0] code_rd, data_rd, code_peek, data_peek;
    logic [WORD_W-1:0] alu_res;
    ctrl_t             ctrl;
    logic              store_we;
    logic              ld_data_we;
    logic              dmem_we;
    logic [MEM_AW-1:0] dmem_waddr;
    logic [WORD_W-1:0] dmem_wdata;

    assign mem_addr = st_q.pc[MEM_AW-1:0];

    accum_stepper_mem #(.W(WORD_W), .AW(MEM_AW)) u_code (
        .clk   (clk),
        .we    (ld_en & ~ld_sel),
        .waddr (ld_addr),
        .wdata (ld_data),
        .ra    (mem_addr),
        .rd    (code_rd),
        .rb    (peek_addr),
        .rdb   (code_peek)
    );

    accum_stepper_mem #(.W(WORD_W), .AW(MEM_AW)) u_data (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .ra    (mem_addr),
        .rd    (data_rd),
        .rb    (peek_addr),
        .rdb   (data_peek)
    );

    accum_stepper_decode u_dec (
        .op   (code_rd),
        .ctrl (ctrl)
    );

    accum_stepper_alu u_alu (
        .acc_in  (st_q.acc),
        .operand (data_rd),
        .ctrl    (ctrl),
        .result  (alu_res)
    );

    // data-store write port: loader wins over a store
    always_comb begin
        store_we   = ctrl.wr_mem & ~st_q.halted & ~clr;
        ld_data_we = ld_en & ld_sel;
        dmem_we    = ld_data_we | store_we;
        dmem_waddr = ld_data_we ? ld_addr : mem_addr;
        dmem_wdata = ld_data_we ? ld_data : st_q.acc;
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.halted) begin
            if (ctrl.stop) begin
                st_d.halted = 1'b1;
            end else begin
                st_d.pc = st_q.pc + PC_W'(1);
                if (ctrl.take_mem | ctrl.use_alu) begin
                    st_d.acc = alu_res;
                end
            end
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign peek_data = peek_sel ? data_peek : code_peek;
    assign acc       = st_q.acc;
    assign pc        = st_q.pc;
    assign halted    = st_q.halted;

endmodule

// File: rtl/accum_stepper_chk.sv
module accum_stepper_chk
    import accum_stepper_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic              clk,
    input logic              clr,
    input logic [PC_W-1:0]   pc,
    input logic [WORD_W-1:0] acc,
    input logic              halted,
    input logic [WORD_W-1:0] opcode,
    input logic [WORD_W-1:0] operand
);

    logic known_op;
    assign known_op = (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                      (opcode == OP_ADD)  || (opcode == OP_SUB)   ||
                      (opcode == OP_HALT);

    assert_clear_R1: assert property (@(posedge clk)
        clr |=> (pc == '0 && acc == '0 && !halted));

    assert_load_R2: assert property (@(posedge clk) disable iff (clr)
        (!halted && opcode == OP_LOAD) |=> acc == $past(operand));

    assert_add_R3: assert property (@(posedge clk) disable iff (clr)
        (!halted && opcode == OP_ADD) |=> acc == WORD_W'($past(acc) + $past(operand)));

    assert_sub_R4: assert property (@(posedge clk) disable iff (clr)
        (!halted && opcode == OP_SUB) |=> acc == WORD_W'($past(acc) - $past(operand)));

    assert_store_R5: assert property (@(posedge clk) disable iff (clr)
        (!halted && opcode == OP_STORE) |=> $stable(acc));

    assert_step_R6: assert property (@(posedge clk) disable iff (clr)
        (!halted && opcode != OP_HALT) |=> pc == PC_W'($past(pc) + 1));

    assert_halt_R7: assert property (@(posedge clk) disable iff (clr)
        (!halted && opcode == OP_HALT) |=> (halted && $stable(pc) && $stable(acc)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (clr)
        halted |=> (halted && $stable(pc) && $stable(acc)));

    assert_nop_R8: assert property (@(posedge clk) disable iff (clr)
        (!halted && !known_op) |=> $stable(acc));

endmodule

bind accum_stepper accum_stepper_chk #(.PC_W(PC_W)) u_chk (
    .clk     (clk),
    .clr     (clr),
    .pc      (pc),
    .acc     (acc),
    .halted  (halted),
    .opcode  (code_rd),
    .operand (data_rd)
);

// File: tb/accum_stepper_bench.sv
module accum_stepper_bench;

    localparam int PC_W   = 16;
    localparam int MEM_AW = 8;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int RUNS   = 24;

    logic              clk = 1'b0;
    logic              clr;
    logic              ld_en;
    logic              ld_sel;
    logic [MEM_AW-1:0] ld_addr;
    logic [7:0]        ld_data;
    logic              peek_sel;
    logic [MEM_AW-1:0] peek_addr;
    logic [7:0]        peek_data;
    logic [7:0]        acc;
    logic [PC_W-1:0]   pc;
    logic              halted;

    always #2 clk = ~clk;

    accum_stepper #(.PC_W(PC_W), .MEM_AW(MEM_AW)) u_accum_stepper (
        .clk       (clk),
        .clr       (clr),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .peek_sel  (peek_sel),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .acc       (acc),
        .pc        (pc),
        .halted    (halted)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench-side expectations
    logic [7:0]      code_m [DEPTH];
    logic [7:0]      data_m [DEPTH];
    logic [7:0]      acc_e;
    logic [PC_W-1:0] pc_e;
    logic            halt_e;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_sel = 1'b0; ld_addr = MEM_AW'(i); ld_data = code_m[i];
            @(negedge clk);
            ld_sel = 1'b1; ld_data = data_m[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic model_step();
        logic [7:0] p;
        logic [7:0] op;
        p  = pc_e[7:0];
        op = code_m[p];
        if (!halt_e) begin
            case (op)
                8'h10: acc_e = data_m[p];
                8'h20: acc_e = acc_e + data_m[p];
                8'h21: acc_e = acc_e - data_m[p];
                8'h11: data_m[p] = acc_e;
                default: ;
            endcase
            if (op == 8'hFF) halt_e = 1'b1;
            else pc_e = pc_e + 16'd1;
        end
    endtask

    task automatic run_steps(int n);
        for (int s = 0; s < n; s++) begin
            model_step();
            @(negedge clk);
            chk("R2/R3/R4/R8", "acc", 32'(acc), 32'(acc_e));
            chk("R6", "pc", 32'(pc), 32'(pc_e));
            chk("R7", "halted", 32'(halted), 32'(halt_e));
        end
    endtask

    task automatic check_data_store(string req);
        for (int a = 0; a < DEPTH; a++) begin
            peek_sel = 1'b1; peek_addr = MEM_AW'(a);
            #1;
            chk(req, "data store", 32'(peek_data), 32'(data_m[a]));
        end
    endtask

    task automatic restart();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        chk("R1", "acc after clear", 32'(acc), 32'h0);
        chk("R1", "pc after clear", 32'(pc), 32'h0);
        chk("R1", "halted after clear", 32'(halted), 32'h0);
        acc_e = 8'h00; pc_e = '0; halt_e = 1'b0;
    endtask

    function automatic logic [7:0] pick_op(int i, int run);
        case ((i + run) % 8)
            0: return 8'h10;
            1: return 8'h20;
            2: return 8'h11;
            3: return 8'h21;
            4: return 8'h12;
            5: return 8'h20;
            6: return 8'(i % 16);
            default: return 8'h21;
        endcase
    endfunction

    initial begin
        clr = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
        peek_sel = 1'b0; peek_addr = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "reset acc", 32'(acc), 32'h0);
        chk("R1", "reset pc", 32'(pc), 32'h0);
        chk("R1", "reset halted", 32'(halted), 32'h0);

        // worked example: load, add, subtract, store, halt, then a store that must not run
        for (int i = 0; i < DEPTH; i++) begin
            code_m[i] = 8'hFF;
            data_m[i] = 8'(i);
        end
        code_m[0] = 8'h10; data_m[0] = 8'h56;
        code_m[1] = 8'h20; data_m[1] = 8'h2A;
        code_m[2] = 8'h21; data_m[2] = 8'h38;
        code_m[3] = 8'h11; data_m[3] = 8'h00;
        code_m[4] = 8'hFF;
        code_m[5] = 8'h11; data_m[5] = 8'h77;
        load_all();
        for (int a = 0; a < DEPTH; a++) begin
            peek_sel = 1'b0; peek_addr = MEM_AW'(a);
            #1;
            chk("R9", "code peek", 32'(peek_data), 32'(code_m[a]));
        end
        check_data_store("R9");
        acc_e = 8'h00; pc_e = '0; halt_e = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        run_steps(1);
        chk("R2", "load 56h", 32'(acc), 32'h56);
        run_steps(1);
        chk("R3", "add gives 80h", 32'(acc), 32'h80);
        run_steps(1);
        chk("R4", "subtract gives 48h", 32'(acc), 32'h48);
        run_steps(1);
        chk("R5", "acc kept by store", 32'(acc), 32'h48);
        run_steps(1);
        chk("R7", "halt raised", 32'(halted), 32'h1);
        chk("R7", "pc held at halt", 32'(pc), 32'h4);
        run_steps(6);
        check_data_store("R5/R7");
        restart();

        // sweeps: mixed programs ending in a halt at the last address
        for (int run = 0; run < RUNS; run++) begin
            for (int i = 0; i < DEPTH; i++) begin
                code_m[i] = pick_op(i, run);
                data_m[i] = 8'(i * 37 + run * 91 + 11);
            end
            code_m[DEPTH-1] = 8'hFF;
            load_all();
            acc_e = 8'h00; pc_e = '0; halt_e = 1'b0;
            @(negedge clk);
            clr = 1'b0;
            run_steps(DEPTH + 3);
            chk("R7", "halted at end", 32'(halted), 32'h1);
            chk("R6", "pc at last address", 32'(pc), 32'(DEPTH - 1));
            check_data_store("R5/R8");
            restart();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule